// File: doc/BRIEF.md
# Exception State and Priority Controller

This block keeps the lifecycle state of a small, fixed set of exception sources and decides which source the processor should enter next. Every source carries two bits of state: a pending flag, set by a one-cycle request pulse, and an active flag, set when the processor acknowledges entry into that source's handler. Handlers can nest. Each entry pushes the exception number onto an internal nest stack, and each handler return pops the most recent one.

Source 0 is the non-maskable interrupt, with fixed level -2. Source 1 is the hard fault, with fixed level -1. Every higher-numbered source has a 4-bit configurable priority and an enable bit. All levels are compared as signed 6-bit values, so both fixed levels outrank every configurable level. The controller offers the best eligible pending source and raises a preempt flag when that source outranks the current execution level. The current execution level is the best level among the active sources, or an idle level of 16 when no source is active. All outputs are registered. They reflect the state after each clock edge, using the priority and enable values sampled at that same edge.

Top module: `exc_ctrl`

## Requirements
- R1: `state_o[2i+1:2i]` gives the state of source i: 00 inactive, 01 pending, 10 active, 11 active-and-pending (bit 2i is the pending flag, bit 2i+1 the active flag). After synchronous reset every source is 00, `preempt_o` and `sel_valid_o` are 0 and `cur_prio_o` is 16.
- R2: A pulse on `req_i[i]` sets the pending flag of source i at the sampling edge. An inactive source becomes pending, and an active source becomes active-and-pending.
- R3: `ack_i` with `preempt_o` high and `ret_i` low clears the pending flag of source `sel_num_o`, sets its active flag and pushes it on the nest. A request for that same source in the same cycle leaves it active-and-pending.
- R4: `ret_i` clears the active flag of the most recently entered source still on the nest. Active becomes inactive, and active-and-pending becomes pending. `ret_i` with an empty nest changes nothing.
- R5: The level of source 0 is -2 and of source 1 is -1. Source i ≥ 2 takes the unsigned value `cfg_prio_i[4(i-2)+3:4(i-2)]`. `cur_prio_o` (signed) is the lowest level over active sources, or 16 when none is active.
- R6: `sel_valid_o` is high when an eligible source is pending. `sel_num_o` is the eligible pending source with the lowest level, and on equal levels it is the lower exception number.
- R7: `preempt_o` is high exactly when the selected level is strictly lower than `cur_prio_o`. A pending source at the same level as the running one does not preempt.
- R8: Source i ≥ 2 with `cfg_en_i[i-2]` low still becomes pending but is never selected. It becomes selectable from the edge at which the enable is sampled high. Sources 0 and 1 have no enable.
- R9: While source 0 is active, `preempt_o` stays low. An active hard fault is preempted only by source 0.
- R10: `ack_i` while `preempt_o` is low, or in a cycle with `ret_i` high, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high clear |
| req_i | input | N_SRC | Per-source request pulses |
| cfg_en_i | input | N_SRC-2 | Enables of configurable sources 2 and up |
| cfg_prio_i | input | (N_SRC-2)*PRIO_W | Priorities of configurable sources, source 2 in the low nibble |
| ack_i | input | 1 | Handler entry for the offered source |
| ret_i | input | 1 | Handler return of the innermost active source |
| state_o | output | 2*N_SRC | Per-source state, two bits each |
| sel_num_o | output | clog2(N_SRC) | Offered exception number |
| sel_valid_o | output | 1 | An eligible source is pending |
| preempt_o | output | 1 | Offered source outranks current execution level |
| cur_prio_o | output | PRIO_W+2 | Signed current execution level |

## Verification
Two pairs of events can land in the same cycle. In the first pair, a handler entry coincides with a new request for the very source being entered. The bench provokes this by pulsing `req_i` and `ack_i` together, and the source must then read active-and-pending. In the second pair, an acknowledge coincides with a handler return. The bench holds both high for one cycle, and it requires that the return pops the nest while the acknowledge leaves every other flag and the offered source untouched.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned NMI_NUM = 0;
  localparam int unsigned HFAULT_NUM = 1;
  localparam int unsigned FIXED_CNT = 2;

  typedef enum logic [1:0] {
    EXS_IDLE     = 2'b00,
    EXS_PEND     = 2'b01,
    EXS_ACT      = 2'b10,
    EXS_ACT_PEND = 2'b11
  } exc_state_e;
endpackage

// File: rtl/exc_src_cell.sv
module exc_src_cell (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req,
  input  logic                  take,
  input  logic                  done,
  output logic                  pend_n,
  output logic                  act_n,
  output exc_pkg::exc_state_e   state
);
  logic pend_q, act_q;

  // a new request outranks the clear caused by entry
  assign pend_n = (pend_q & ~take) | req;
  assign act_n  = (act_q & ~done) | take;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      act_q  <= act_n;
    end
  end

  assign state = exc_pkg::exc_state_e'({act_q, pend_q});
endmodule

// File: rtl/exc_nest_stack.sv
module exc_nest_stack #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic [IDX_W-1:0] top_idx,
  output logic             nonempty
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int ADR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] cnt;
  logic [PTR_W-1:0] cnt_m1;

  assign cnt_m1 = cnt - PTR_W'(1);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (pop)
      cnt <= cnt_m1;
    else if (push)
      cnt <= cnt + PTR_W'(1);
  end

  // storage without reset so it can map onto distributed RAM
  always_ff @(posedge clk) begin
    if (push && !pop)
      mem[cnt[ADR_W-1:0]] <= push_idx;
  end

  assign top_idx  = mem[cnt_m1[ADR_W-1:0]];
  assign nonempty = (cnt != '0);
endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 4
) (
  input  logic [N_SRC-1:0]                pend,
  input  logic [N_SRC-1:0]                act,
  input  logic [N_SRC-3:0]                cfg_en,
  input  logic [(N_SRC-2)*PRIO_W-1:0]     cfg_prio,
  output logic [$clog2(N_SRC)-1:0]        best_idx,
  output logic                            best_vld,
  output logic signed [PRIO_W+1:0]        best_lvl,
  output logic signed [PRIO_W+1:0]        cur_lvl
);
  localparam int IDX_W = $clog2(N_SRC);
  localparam int LVL_W = PRIO_W + 2;
  localparam logic signed [LVL_W-1:0] IDLE_LVL = LVL_W'(1 << PRIO_W);

  logic signed [LVL_W-1:0] lvl [N_SRC];
  logic [N_SRC-1:0] elig;

  for (genvar i = 0; i < N_SRC; i++) begin : g_lvl
    if (i == exc_pkg::NMI_NUM) begin : g_nmi
      assign lvl[i]  = LVL_W'(-2);
      assign elig[i] = pend[i];
    end else if (i == exc_pkg::HFAULT_NUM) begin : g_hf
      assign lvl[i]  = LVL_W'(-1);
      assign elig[i] = pend[i];
    end else begin : g_cfg
      assign lvl[i]  = $signed({2'b00, cfg_prio[(i-2)*PRIO_W +: PRIO_W]});
      assign elig[i] = pend[i] & cfg_en[i-2];
    end
  end

  // ascending scan with strict compare keeps the lower number on ties
  always_comb begin
    best_vld = 1'b0;
    best_idx = '0;
    best_lvl = IDLE_LVL;
    cur_lvl  = IDLE_LVL;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!best_vld || lvl[i] < best_lvl)) begin
        best_vld = 1'b1;
        best_idx = IDX_W'(i);
        best_lvl = lvl[i];
      end
      if (act[i] && lvl[i] < cur_lvl)
        cur_lvl = lvl[i];
    end
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [N_SRC-1:0]                req_i,
  input  logic [N_SRC-3:0]                cfg_en_i,
  input  logic [(N_SRC-2)*PRIO_W-1:0]     cfg_prio_i,
  input  logic                            ack_i,
  input  logic                            ret_i,
  output logic [2*N_SRC-1:0]              state_o,
  output logic [$clog2(N_SRC)-1:0]        sel_num_o,
  output logic                            sel_valid_o,
  output logic                            preempt_o,
  output logic signed [PRIO_W+1:0]        cur_prio_o
);
  localparam int IDX_W = $clog2(N_SRC);
  localparam int LVL_W = PRIO_W + 2;
  localparam logic signed [LVL_W-1:0] IDLE_LVL = LVL_W'(1 << PRIO_W);

  logic [N_SRC-1:0] pend_n, act_n, take, done;
  logic [IDX_W-1:0] top_idx;
  logic             nest_nonempty;
  logic             do_ack, do_ret;
  exc_pkg::exc_state_e cell_st [N_SRC];

  logic [IDX_W-1:0]        best_idx;
  logic                    best_vld;
  logic signed [LVL_W-1:0] best_lvl, cur_lvl;

  // return wins over entry in the same cycle
  assign do_ret = ret_i & nest_nonempty;
  assign do_ack = ack_i & preempt_o & ~ret_i;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign take[i] = do_ack & (sel_num_o == IDX_W'(i));
    assign done[i] = do_ret & (top_idx == IDX_W'(i));

    exc_src_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .req    (req_i[i]),
      .take   (take[i]),
      .done   (done[i]),
      .pend_n (pend_n[i]),
      .act_n  (act_n[i]),
      .state  (cell_st[i])
    );

    assign state_o[2*i +: 2] = cell_st[i];
  end

  exc_nest_stack #(
    .DEPTH (N_SRC),
    .IDX_W (IDX_W)
  ) u_nest (
    .clk      (clk),
    .rst      (rst),
    .push     (do_ack),
    .push_idx (sel_num_o),
    .pop      (do_ret),
    .top_idx  (top_idx),
    .nonempty (nest_nonempty)
  );

  exc_prio_sel #(
    .N_SRC  (N_SRC),
    .PRIO_W (PRIO_W)
  ) u_sel (
    .pend     (pend_n),
    .act      (act_n),
    .cfg_en   (cfg_en_i),
    .cfg_prio (cfg_prio_i),
    .best_idx (best_idx),
    .best_vld (best_vld),
    .best_lvl (best_lvl),
    .cur_lvl  (cur_lvl)
  );

  // decisions are made on next-state so outputs line up with state_o
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_num_o   <= '0;
      sel_valid_o <= 1'b0;
      preempt_o   <= 1'b0;
      cur_prio_o  <= IDLE_LVL;
    end else begin
      sel_num_o   <= best_idx;
      sel_valid_o <= best_vld;
      preempt_o   <= best_vld && (best_lvl < cur_lvl);
      cur_prio_o  <= cur_lvl;
    end
  end
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic [N_SRC-1:0]            req_i,
  input logic                        ack_i,
  input logic                        ret_i,
  input logic [2*N_SRC-1:0]          state_o,
  input logic [$clog2(N_SRC)-1:0]    sel_num_o,
  input logic                        sel_valid_o,
  input logic                        preempt_o,
  input logic signed [PRIO_W+1:0]    cur_prio_o
);
  localparam int IDX_W = $clog2(N_SRC);
  localparam int LVL_W = PRIO_W + 2;
  localparam logic signed [LVL_W-1:0] IDLE_LVL = LVL_W'(1 << PRIO_W);

  logic [N_SRC-1:0] act_v;
  logic             acc_d;
  logic [IDX_W-1:0] sel_d;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) act_v[i] = state_o[2*i+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_d <= 1'b0;
      sel_d <= '0;
    end else begin
      acc_d <= ack_i & preempt_o & ~ret_i;
      sel_d <= sel_num_o;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (state_o == '0 && !preempt_o && !sel_valid_o));

  assert_req_sets_pend_R2: assert property (@(posedge clk) disable iff (rst)
    req_i[0] |=> state_o[0]);

  assert_no_spurious_pend_R2: assert property (@(posedge clk) disable iff (rst)
    (!state_o[0] && !req_i[0]) |=> !state_o[0]);

  assert_ack_activates_R3: assert property (@(posedge clk) disable iff (rst)
    acc_d |-> state_o[2*sel_d+1]);

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (rst)
    (act_v == '0) |-> (cur_prio_o == IDLE_LVL));

  assert_preempt_pending_R7: assert property (@(posedge clk) disable iff (rst)
    preempt_o |-> (sel_valid_o && state_o[2*sel_num_o]));

  assert_nmi_unpreempted_R9: assert property (@(posedge clk) disable iff (rst)
    state_o[1] |-> !preempt_o);
endmodule

bind exc_ctrl exc_ctrl_chk #(
  .N_SRC  (N_SRC),
  .PRIO_W (PRIO_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_i       (req_i),
  .ack_i       (ack_i),
  .ret_i       (ret_i),
  .state_o     (state_o),
  .sel_num_o   (sel_num_o),
  .sel_valid_o (sel_valid_o),
  .preempt_o   (preempt_o),
  .cur_prio_o  (cur_prio_o)
);

// File: tb/tb_exc_ctrl.sv
`timescale 1ns/1ps
module tb_exc_ctrl;
  localparam int N = 8;
  localparam int PW = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [N-1:0]      req = '0;
  logic [N-3:0]      en  = '1;
  logic [(N-2)*PW-1:0] prio = 24'hF09255; // src7..src2 = 15,0,9,2,5,5
  logic              ack = 1'b0;
  logic              ret = 1'b0;
  logic [2*N-1:0]    st;
  logic [2:0]        sel;
  logic              vld, pre;
  logic signed [PW+1:0] cur;
  logic [5:0]        cur_u;
  assign cur_u = cur;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exc_ctrl #(.N_SRC(N), .PRIO_W(PW)) dut (
    .clk(clk), .rst(rst), .req_i(req), .cfg_en_i(en), .cfg_prio_i(prio),
    .ack_i(ack), .ret_i(ret), .state_o(st), .sel_num_o(sel),
    .sel_valid_o(vld), .preempt_o(pre), .cur_prio_o(cur)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        ack;
    logic        ret;
    logic [15:0] st;
    logic [2:0]  sel;
    logic        vld;
    logic        pre;
    logic [5:0]  cur;
  } vec_t;

  localparam vec_t VEC [16] = '{
    {8'h04, 1'b0, 1'b0, 16'h0010, 3'd2, 1'b1, 1'b1, 6'h10},
    {8'h00, 1'b1, 1'b0, 16'h0020, 3'd0, 1'b0, 1'b0, 6'h05},
    {8'h08, 1'b0, 1'b0, 16'h0060, 3'd3, 1'b1, 1'b0, 6'h05},
    {8'h00, 1'b1, 1'b0, 16'h0060, 3'd3, 1'b1, 1'b0, 6'h05},
    {8'h10, 1'b0, 1'b0, 16'h0160, 3'd4, 1'b1, 1'b1, 6'h05},
    {8'h04, 1'b1, 1'b0, 16'h0270, 3'd2, 1'b1, 1'b0, 6'h02},
    {8'h42, 1'b0, 1'b0, 16'h1274, 3'd1, 1'b1, 1'b1, 6'h02},
    {8'h00, 1'b1, 1'b0, 16'h1278, 3'd6, 1'b1, 1'b0, 6'h3F},
    {8'h01, 1'b0, 1'b0, 16'h1279, 3'd0, 1'b1, 1'b1, 6'h3F},
    {8'h00, 1'b1, 1'b0, 16'h127A, 3'd6, 1'b1, 1'b0, 6'h3E},
    {8'h02, 1'b0, 1'b0, 16'h127E, 3'd1, 1'b1, 1'b0, 6'h3E},
    {8'h00, 1'b0, 1'b1, 16'h127C, 3'd1, 1'b1, 1'b0, 6'h3F},
    {8'h00, 1'b0, 1'b1, 16'h1274, 3'd1, 1'b1, 1'b1, 6'h02},
    {8'h00, 1'b1, 1'b1, 16'h1074, 3'd1, 1'b1, 1'b1, 6'h05},
    {8'h00, 1'b1, 1'b0, 16'h1078, 3'd6, 1'b1, 1'b0, 6'h3F},
    {8'h00, 1'b0, 1'b1, 16'h1070, 3'd6, 1'b1, 1'b1, 6'h05}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic [7:0] r, input logic a, input logic t);
    req = r; ack = a; ret = t;
    @(negedge clk);
    req = '0; ack = 1'b0; ret = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset state", 32'(st), 32'h0);
    chk("R1 reset preempt", 32'(pre), 32'h0);
    chk("R1 reset valid", 32'(vld), 32'h0);
    chk("R1 reset cur_prio", 32'(cur_u), 32'h10);

    for (int k = 0; k < 16; k++) begin
      step(VEC[k].req, VEC[k].ack, VEC[k].ret);
      chk($sformatf("R2 R3 R4 R10 state vec %0d", k), 32'(st), 32'(VEC[k].st));
      chk($sformatf("R6 valid vec %0d", k), 32'(vld), 32'(VEC[k].vld));
      if (VEC[k].vld)
        chk($sformatf("R6 sel vec %0d", k), 32'(sel), 32'(VEC[k].sel));
      chk($sformatf("R7 R9 preempt vec %0d", k), 32'(pre), 32'(VEC[k].pre));
      chk($sformatf("R5 cur_prio vec %0d", k), 32'(cur_u), 32'(VEC[k].cur));
    end

    // R1 mid-run reset, then R4 return on an empty nest
    do_reset();
    chk("R1 clear state", 32'(st), 32'h0);
    chk("R1 clear cur_prio", 32'(cur_u), 32'h10);
    chk("R1 clear preempt", 32'(pre), 32'h0);
    step(8'h00, 1'b0, 1'b1);
    chk("R4 empty return state", 32'(st), 32'h0);
    chk("R4 empty return cur_prio", 32'(cur_u), 32'h10);

    // R8 disabled source pends but is not offered
    en = 6'h37;
    step(8'h20, 1'b0, 1'b0);
    chk("R8 disabled pend state", 32'(st), 32'h0400);
    chk("R8 disabled not valid", 32'(vld), 32'h0);
    chk("R8 disabled no preempt", 32'(pre), 32'h0);
    en = 6'h3F;
    step(8'h00, 1'b0, 1'b0);
    chk("R8 enabled sel", 32'(sel), 32'd5);
    chk("R8 enabled preempt", 32'(pre), 32'h1);

    // R9 NMI runs; hard fault request cannot preempt it
    step(8'h01, 1'b0, 1'b0);
    chk("R6 nmi sel", 32'(sel), 32'd0);
    step(8'h00, 1'b1, 1'b0);
    chk("R3 nmi active", 32'(st), 32'h0402);
    chk("R5 nmi level", 32'(cur_u), 32'h3E);
    step(8'h02, 1'b0, 1'b0);
    chk("R9 hf pending under nmi sel", 32'(sel), 32'd1);
    chk("R9 hf no preempt", 32'(pre), 32'h0);
    step(8'h00, 1'b1, 1'b0);
    chk("R10 ack ignored state", 32'(st), 32'h0406);
    step(8'h00, 1'b0, 1'b1);
    chk("R4 nmi return state", 32'(st), 32'h0404);
    chk("R7 hf preempt after return", 32'(pre), 32'h1);
    step(8'h00, 1'b1, 1'b0);
    chk("R5 hf level", 32'(cur_u), 32'h3F);
    chk("R7 cfg no preempt over hf", 32'(pre), 32'h0);
    step(8'h01, 1'b0, 1'b0);
    chk("R9 nmi preempts hf", 32'(pre), 32'h1);
    chk("R9 nmi sel", 32'(sel), 32'd0);

    // R3 entry and new request for the same source in one cycle
    do_reset();
    step(8'h80, 1'b0, 1'b0);
    chk("R5 lowest cfg level preempts idle", 32'(pre), 32'h1);
    step(8'h80, 1'b1, 1'b0);
    chk("R3 same source active and pending", 32'(st), 32'hC000);
    chk("R5 cur level 15", 32'(cur_u), 32'h0F);
    chk("R7 equal level no preempt", 32'(pre), 32'h0);
    step(8'h00, 1'b0, 1'b1);
    chk("R4 return falls back to pending", 32'(st), 32'h4000);
    chk("R7 repending preempts", 32'(pre), 32'h1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule